// File: doc/BRIEF.md
# Tiled Frame Buffer Address Translator

This block turns a pixel coordinate and a colour depth into the byte address of that pixel in a frame buffer. In tiled layout every 2048-byte memory page holds a small rectangle of the screen rather than a run of one scan line. Drawing that moves vertically or stays inside a small area therefore touches few pages. For 8, 16 and 32 bits per pixel the rectangle is 256 bytes wide and 8 lines tall. For 24 bits per pixel, with pixels packed at three bytes, the rectangle is 64 pixels (192 bytes) wide and 10 lines tall. That shape fills 1920 bytes of each page and leaves the top 128 bytes of the page unused.

A plain scan-line (linear) layout with a programmable pitch can be selected for each request. A request carries the coordinate, the depth, the layout, the screen width in tiles, the screen height in lines, the pitch and a base address. Requests enter through a valid/ready handshake. Results leave through a second valid/ready handshake, two stages later. Each result gives the byte address, a page index and an out-of-screen flag.

Top module: `tiled_fb_addr_xlate`

## Requirements
- R1: In tiled layout with depth code 0 (1 byte/pixel), 1 (2 bytes/pixel) or 3 (4 bytes/pixel), a tile is 256 bytes wide and 8 lines tall, so it is 256/bpp pixels wide. col = x / (256/bpp) and row = y / 8. The page index is row*tiles_per_row + col. The address is base + page*2048 + (y%8)*256 + (x%(256/bpp))*bpp.
- R2: In tiled layout with depth code 2 (3 bytes/pixel, packed with no padding), a tile is 64 pixels by 10 lines. The page index is (y/10)*tiles_per_row + x/64. The address is base + page*2048 + (y%10)*192 + (x%64)*3.
- R3: In tiled 3-byte mode, the offset of the address inside its page (address minus base, modulo 2048) is always below 1920. Bytes 1920..2047 of a page are never produced.
- R4: In linear layout (req_tiled = 0), the address is base + y*pitch + x*bpp. The page index is (y*pitch + x*bpp) / 2048.
- R5: req_depth selects 1, 2, 3 or 4 bytes per pixel for codes 0, 1, 2 and 3. req_tiled = 1 selects tiled layout.
- R6: out_err is 1 when x >= tiles_per_row * tile_width_pixels (tile width from R1/R2 for the depth, in either layout) or when y >= lines. The address and page are still computed by the normal rule for that layout.
- R7: A request accepted on a clock edge yields out_valid after the following edge. With out_ready held high, one request is accepted every cycle with no stall.
- R8: While out_valid is 1 and out_ready is 0, out_addr, out_page and out_err stay unchanged on the next cycle and out_valid stays 1. Results leave in request order.
- R9: While rst_n is low at a clock edge, both stages empty: after reset out_valid is 0 and req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken on this edge when valid |
| req_x | input | XW | Pixel column |
| req_y | input | YW | Pixel line |
| req_depth | input | 2 | Depth code: 0=8, 1=16, 2=24, 3=32 bpp |
| req_tiled | input | 1 | 1 = tiled layout, 0 = linear |
| req_tiles_per_row | input | TW | Screen width in tiles |
| req_lines | input | YW | Screen height in lines |
| req_pitch | input | PW | Linear line pitch in bytes |
| req_base | input | AW | Frame buffer base byte address |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result consumed on this edge when valid |
| out_addr | output | AW | Byte address of the pixel |
| out_page | output | AW-11 | Page index relative to base |
| out_err | output | 1 | Coordinate lies outside the screen |

## Verification
The assertions assume that the request fields are known whenever req_valid is high. They also assume that a stalled result is not abandoned: out_ready only releases it. Widths are assumed wide enough that page and address sums never wrap. The stimulus keeps tiles_per_row and lines small enough that every page index fits. It drives every field from a known value at the start. It changes out_ready only between edges, so the holding rule is exercised under a defined stall pattern.

// File: rtl/fbx_pkg.sv
// Shared types for the frame buffer address translator.
// Assumes a 2048-byte memory page.
package fbx_pkg;
    typedef enum logic [1:0] {
        PIX8  = 2'd0,
        PIX16 = 2'd1,
        PIX24 = 2'd2,
        PIX32 = 2'd3
    } pix_depth_e;

    localparam int unsigned PAGE_SHIFT = 11;

    // Bytes occupied by one pixel of the given depth.
    function automatic logic [2:0] bytes_per_pixel(input pix_depth_e d);
        case (d)
            PIX8:    return 3'd1;
            PIX16:   return 3'd2;
            PIX24:   return 3'd3;
            default: return 3'd4;
        endcase
    endfunction
endpackage

// File: rtl/fbx_div10.sv
// Constant divide-by-ten using a scaled reciprocal multiply.
// Assumes W >= 4; the result is exact for every W-bit input.
module fbx_div10 #(
    parameter int unsigned W = 12
) (
    input  logic [W-1:0] num,
    output logic [W-1:0] quo,
    output logic [3:0]   rem
);
    localparam int unsigned K   = W + 4;
    localparam int unsigned PRW = W + K;
    localparam longint unsigned MUL = ((64'd1 << K) + 64'd9) / 64'd10;

    logic [PRW-1:0] prod;
    logic [W-1:0]   back;

    // Multiply by the rounded-up reciprocal and keep the high part.
    always_comb begin
        prod = PRW'(num) * PRW'(MUL);
        quo  = prod[PRW-1:K];
        back = quo * W'(10);
        rem  = 4'(num - back);
    end

    // Guard the reciprocal: the quotient and remainder must rebuild the input (R2).
    always_comb begin
        if (!$isunknown(num)) begin
            a_r2_div_exact: assert (rem < 4'd10 && back + W'(rem) == num)
                else $error("divide by ten mismatch");
        end
    end
endmodule

// File: rtl/fbx_tile_split.sv
// First stage logic: splits a coordinate into tile column/row and the
// position inside the tile, and flags coordinates outside the screen.
// Assumes XW >= 8.
module fbx_tile_split
    import fbx_pkg::*;
#(
    parameter int unsigned XW = 12,
    parameter int unsigned YW = 12,
    parameter int unsigned TW = 5
) (
    input  logic [XW-1:0] x,
    input  logic [YW-1:0] y,
    input  pix_depth_e    depth,
    input  logic [TW-1:0] tiles_per_row,
    input  logic [YW-1:0] lines,
    output logic [XW-1:0] col,
    output logic [YW-1:0] row,
    output logic [7:0]    x_in,
    output logic [3:0]    y_in,
    output logic          err
);
    localparam int unsigned CW = (XW > TW + 8) ? XW : TW + 8;

    logic [YW-1:0] q10;
    logic [3:0]    r10;
    logic [3:0]    px_shift;
    logic [CW-1:0] width_px;

    fbx_div10 #(.W(YW)) i_div10 (
        .num (y),
        .quo (q10),
        .rem (r10)
    );

    // Horizontal split: tile width in pixels is a power of two for every depth.
    always_comb begin
        case (depth)
            PIX8: begin
                px_shift = 4'd8;
                col      = x >> 8;
                x_in     = x[7:0];
            end
            PIX16: begin
                px_shift = 4'd7;
                col      = x >> 7;
                x_in     = {1'b0, x[6:0]};
            end
            default: begin
                px_shift = 4'd6;
                col      = x >> 6;
                x_in     = {2'b00, x[5:0]};
            end
        endcase
    end

    // Vertical split: ten-line tiles for packed 3-byte pixels, eight otherwise.
    always_comb begin
        if (depth == PIX24) begin
            row  = q10;
            y_in = r10;
        end else begin
            row  = y >> 3;
            y_in = {1'b0, y[2:0]};
        end
    end

    // Screen bounds check against width in pixels and height in lines.
    always_comb begin
        width_px = CW'(tiles_per_row) << px_shift;
        err      = (CW'(x) >= width_px) || (y >= lines);
    end
endmodule

// File: rtl/fbx_addr_build.sv
// Second stage logic: forms the byte address and page index for either layout.
// Assumes PGW covers the row*tiles_per_row+col range and AW the pitch product.
module fbx_addr_build
    import fbx_pkg::*;
#(
    parameter int unsigned XW = 12,
    parameter int unsigned YW = 12,
    parameter int unsigned TW = 5,
    parameter int unsigned PW = 14,
    parameter int unsigned AW = 32
) (
    input  logic             tiled,
    input  pix_depth_e       depth,
    input  logic [XW-1:0]    col,
    input  logic [YW-1:0]    row,
    input  logic [7:0]       x_in,
    input  logic [3:0]       y_in,
    input  logic [XW-1:0]    x,
    input  logic [YW-1:0]    y,
    input  logic [TW-1:0]    tiles_per_row,
    input  logic [PW-1:0]    pitch,
    input  logic [AW-1:0]    base,
    output logic [AW-1:0]    addr,
    output logic [AW-PAGE_SHIFT-1:0] page
);
    localparam int unsigned PGW = AW - PAGE_SHIFT;

    logic [2:0]            bpp;
    logic [PAGE_SHIFT-1:0] line_bytes;
    logic [PAGE_SHIFT-1:0] in_page;
    logic [PGW-1:0]        page_t;
    logic [AW-1:0]         lin_off;

    // Per-depth constants: bytes per pixel and bytes per tile line.
    always_comb begin
        bpp        = bytes_per_pixel(depth);
        line_bytes = (depth == PIX24) ? PAGE_SHIFT'(192) : PAGE_SHIFT'(256);
    end

    // Tiled offset inside the page and page number.
    always_comb begin
        in_page = PAGE_SHIFT'(y_in) * line_bytes + PAGE_SHIFT'(x_in) * PAGE_SHIFT'(bpp);
        page_t  = PGW'(row) * PGW'(tiles_per_row) + PGW'(col);
    end

    // Linear offset from base.
    always_comb begin
        lin_off = AW'(y) * AW'(pitch) + AW'(x) * AW'(bpp);
    end

    // Layout select for the final address and page.
    always_comb begin
        if (tiled) begin
            addr = base + {page_t, {PAGE_SHIFT{1'b0}}} + AW'(in_page);
            page = page_t;
        end else begin
            addr = base + lin_off;
            page = lin_off[AW-1:PAGE_SHIFT];
        end
    end
endmodule

// File: rtl/tiled_fb_addr_xlate.sv
// Two-stage pipelined pixel-to-address translator for a tiled or linear
// frame buffer. Stage 1 splits the coordinate, stage 2 builds the address.
// Assumes requests hold their fields stable while req_valid waits for req_ready.
module tiled_fb_addr_xlate
    import fbx_pkg::*;
#(
    parameter int unsigned XW = 12,
    parameter int unsigned YW = 12,
    parameter int unsigned TW = 5,
    parameter int unsigned PW = 14,
    parameter int unsigned AW = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [XW-1:0]            req_x,
    input  logic [YW-1:0]            req_y,
    input  logic [1:0]               req_depth,
    input  logic                     req_tiled,
    input  logic [TW-1:0]            req_tiles_per_row,
    input  logic [YW-1:0]            req_lines,
    input  logic [PW-1:0]            req_pitch,
    input  logic [AW-1:0]            req_base,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [AW-1:0]            out_addr,
    output logic [AW-PAGE_SHIFT-1:0] out_page,
    output logic                     out_err
);
    localparam int unsigned PGW = AW - PAGE_SHIFT;

    logic          adv;
    logic          s1_v;
    logic          s2_v;

    logic [XW-1:0] sp_col;
    logic [YW-1:0] sp_row;
    logic [7:0]    sp_xin;
    logic [3:0]    sp_yin;
    logic          sp_err;

    logic [XW-1:0] s1_col;
    logic [YW-1:0] s1_row;
    logic [7:0]    s1_xin;
    logic [3:0]    s1_yin;
    logic          s1_err;
    logic [XW-1:0] s1_x;
    logic [YW-1:0] s1_y;
    pix_depth_e    s1_depth;
    logic          s1_tiled;
    logic [TW-1:0] s1_tpr;
    logic [PW-1:0] s1_pitch;
    logic [AW-1:0] s1_base;

    logic [AW-1:0]  bd_addr;
    logic [PGW-1:0] bd_page;

    logic [AW-1:0]  s2_addr;
    logic [PGW-1:0] s2_page;
    logic           s2_err;

    // Whole pipeline advances unless the output holds an unconsumed result.
    always_comb begin
        adv       = !s2_v || out_ready;
        req_ready = adv;
    end

    fbx_tile_split #(.XW(XW), .YW(YW), .TW(TW)) i_split (
        .x             (req_x),
        .y             (req_y),
        .depth         (pix_depth_e'(req_depth)),
        .tiles_per_row (req_tiles_per_row),
        .lines         (req_lines),
        .col           (sp_col),
        .row           (sp_row),
        .x_in          (sp_xin),
        .y_in          (sp_yin),
        .err           (sp_err)
    );

    // Stage valid flags with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v <= 1'b0;
            s2_v <= 1'b0;
        end else if (adv) begin
            s1_v <= req_valid;
            s2_v <= s1_v;
        end
    end

    // Stage 1 data capture.
    always_ff @(posedge clk) begin
        if (adv && req_valid) begin
            s1_col   <= sp_col;
            s1_row   <= sp_row;
            s1_xin   <= sp_xin;
            s1_yin   <= sp_yin;
            s1_err   <= sp_err;
            s1_x     <= req_x;
            s1_y     <= req_y;
            s1_depth <= pix_depth_e'(req_depth);
            s1_tiled <= req_tiled;
            s1_tpr   <= req_tiles_per_row;
            s1_pitch <= req_pitch;
            s1_base  <= req_base;
        end
    end

    fbx_addr_build #(.XW(XW), .YW(YW), .TW(TW), .PW(PW), .AW(AW)) i_build (
        .tiled         (s1_tiled),
        .depth         (s1_depth),
        .col           (s1_col),
        .row           (s1_row),
        .x_in          (s1_xin),
        .y_in          (s1_yin),
        .x             (s1_x),
        .y             (s1_y),
        .tiles_per_row (s1_tpr),
        .pitch         (s1_pitch),
        .base          (s1_base),
        .addr          (bd_addr),
        .page          (bd_page)
    );

    // Stage 2 data capture.
    always_ff @(posedge clk) begin
        if (adv && s1_v) begin
            s2_addr <= bd_addr;
            s2_page <= bd_page;
            s2_err  <= s1_err;
        end
    end

    // Output drive.
    always_comb begin
        out_valid = s2_v;
        out_addr  = s2_addr;
        out_page  = s2_page;
        out_err   = s2_err;
    end

    // R8: a stalled result stays put.
    a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)
                                       && $stable(out_page) && $stable(out_err)))
        else $error("stalled result changed");

    // R7: an accepted request appears at the output two edges later.
    a_r7_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> ##1 out_valid)
        else $error("accepted request did not reach output");

    // R3: packed tiles never reach past 64 pixels by 10 lines.
    a_r3_packed_box: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_v && s1_tiled && s1_depth == PIX24) |-> (s1_xin < 8'd64 && s1_yin < 4'd10))
        else $error("packed tile position out of range");

    // R1: power-of-two tiles stay within 8 lines.
    a_r1_tile_lines: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_v && s1_tiled && s1_depth != PIX24) |-> (s1_yin < 4'd8))
        else $error("tile line out of range");
endmodule

// File: tb/test_tiled_fb_addr_xlate.sv
module test_tiled_fb_addr_xlate;
    localparam int XW = 12, YW = 12, TW = 5, PW = 14, AW = 32;
    localparam int PGW = AW - 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [XW-1:0] req_x = '0;
    logic [YW-1:0] req_y = '0;
    logic [1:0] req_depth = '0;
    logic req_tiled = 1'b1;
    logic [TW-1:0] req_tiles_per_row = 5'd10;
    logic [YW-1:0] req_lines = 12'd600;
    logic [PW-1:0] req_pitch = 14'd5120;
    logic [AW-1:0] req_base = 32'h0010_0000;
    logic out_valid;
    logic out_ready = 1'b1;
    logic [AW-1:0] out_addr;
    logic [PGW-1:0] out_page;
    logic out_err;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit bp_mode = 0;
    int cyc = 0;

    logic [AW-1:0]  q_addr[$];
    logic [PGW-1:0] q_page[$];
    logic           q_err[$];
    logic [AW-1:0]  q_base[$];
    bit             q_packed[$];
    string          q_tag[$];

    tiled_fb_addr_xlate #(.XW(XW), .YW(YW), .TW(TW), .PW(PW), .AW(AW)) i_tiled_fb_addr_xlate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_x(req_x), .req_y(req_y), .req_depth(req_depth), .req_tiled(req_tiled),
        .req_tiles_per_row(req_tiles_per_row), .req_lines(req_lines),
        .req_pitch(req_pitch), .req_base(req_base), .out_valid(out_valid),
        .out_ready(out_ready), .out_addr(out_addr), .out_page(out_page), .out_err(out_err)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string what, input longint got, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", what, got, exp);
        end
    endtask

    // Expected result from the requirement formulas.
    task automatic model(input int x, input int y, input int d, input bit t,
                         output logic [AW-1:0] a, output logic [PGW-1:0] p, output logic e);
        longint bpp, tw, th, tpx, col, row, pg, off;
        bpp = d + 1;
        tw  = (d == 2) ? 192 : 256;
        th  = (d == 2) ? 10 : 8;
        tpx = tw / bpp;
        e = (x >= longint'(req_tiles_per_row) * tpx) || (y >= int'(req_lines));
        if (t) begin
            col = x / tpx;
            row = y / th;
            pg  = row * longint'(req_tiles_per_row) + col;
            a = AW'(longint'(req_base) + pg * 2048 + (y % th) * tw + (x % tpx) * bpp);
            p = PGW'(pg);
        end else begin
            off = longint'(y) * longint'(req_pitch) + longint'(x) * bpp;
            a = AW'(longint'(req_base) + off);
            p = PGW'(off / 2048);
        end
    endtask

    // Driver: called at a falling edge; returns at a falling edge after acceptance.
    task automatic send(input int x, input int y, input int d, input bit t,
                        input string tag, output int waits);
        logic [AW-1:0] a; logic [PGW-1:0] p; logic e;
        waits = 0;
        req_x = XW'(x); req_y = YW'(y); req_depth = 2'(d); req_tiled = t;
        req_valid = 1'b1;
        while (!req_ready) begin
            @(negedge clk);
            waits++;
        end
        model(x, y, d, t, a, p, e);
        q_addr.push_back(a); q_page.push_back(p); q_err.push_back(e);
        q_base.push_back(req_base); q_packed.push_back(t && d == 2); q_tag.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Output consumer pattern, changed only between edges.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #2 out_ready = bp_mode ? ((cyc % 3) != 0) : 1'b1;
    end

    // Monitor: compares results and checks holding under stall.
    logic [AW-1:0] h_addr; logic [PGW-1:0] h_page; logic h_err; bit h_stall = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (h_stall) begin
                chk(out_valid && out_addr == h_addr && out_page == h_page && out_err == h_err,
                    "R8 held result", out_addr, h_addr);
            end
            h_stall = 0;
            if (out_valid && !out_ready) begin
                h_stall = 1; h_addr = out_addr; h_page = out_page; h_err = out_err;
            end
            if (out_valid && out_ready) begin
                if (q_addr.size() == 0) begin
                    chk(0, "R8 unexpected result", out_addr, 0);
                end else begin
                    logic [AW-1:0] ea; logic [PGW-1:0] ep; logic ee; logic [AW-1:0] eb;
                    bit pk; string tg;
                    ea = q_addr.pop_front(); ep = q_page.pop_front(); ee = q_err.pop_front();
                    eb = q_base.pop_front(); pk = q_packed.pop_front(); tg = q_tag.pop_front();
                    chk(out_addr == ea, {tg, " addr"}, out_addr, ea);
                    chk(out_page == ep, {tg, " page"}, out_page, ep);
                    chk(out_err == ee, {tg, " err"}, out_err, ee);
                    if (pk) chk(((out_addr - eb) & 32'h7FF) < 32'd1920,
                                "R3 page offset", (out_addr - eb) & 32'h7FF, 1920);
                end
            end
        end
    end

    task automatic drain();
        while (q_addr.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired: got 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int w;
        int stalls;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R9 out_valid in reset", out_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R9 out_valid after reset", out_valid, 0);
        chk(req_ready == 1'b1, "R9 req_ready after reset", req_ready, 1);

        // R7 latency from an idle pipeline.
        send(300, 17, 0, 1, "R7 single", w);
        chk(out_valid == 1'b0, "R7 not yet valid", out_valid, 0);
        @(negedge clk);
        chk(out_valid == 1'b1, "R7 valid after second edge", out_valid, 1);
        drain();

        // R1 and R5 tiled power-of-two depths.
        send(0, 0, 0, 1, "R1 origin d8", w);
        send(2559, 599, 0, 1, "R1 far corner d8", w);
        send(200, 9, 1, 1, "R1 d16", w);
        send(130, 23, 3, 1, "R5 d32 tiled", w);
        send(639, 7, 3, 1, "R1 d32 edge", w);
        // R2 packed 3-byte tiles, row boundaries at 10 lines.
        send(63, 9, 2, 1, "R2 last byte of tile", w);
        send(64, 10, 2, 1, "R2 next tile", w);
        send(5, 20, 2, 1, "R2 third row", w);
        send(639, 599, 2, 1, "R2 last pixel", w);
        // R4 linear layout, all depths.
        send(10, 3, 0, 0, "R4 linear d8", w);
        send(100, 50, 1, 0, "R4 linear d16", w);
        send(333, 77, 2, 0, "R4 linear d24", w);
        send(639, 599, 3, 0, "R4 linear d32", w);
        // R6 out-of-screen coordinates.
        send(640, 0, 2, 1, "R6 x past width d24", w);
        send(0, 600, 0, 1, "R6 y past height", w);
        send(2560, 5, 0, 0, "R6 x past width linear", w);
        drain();

        // R7 throughput with out_ready high.
        stalls = 0;
        for (int i = 0; i < 8; i++) begin
            send(i * 71, i * 13, i % 4, i[0], "R7 stream", w);
            stalls += w;
        end
        chk(stalls == 0, "R7 no stall when ready", stalls, 0);
        drain();

        // R8 backpressure and ordering.
        bp_mode = 1;
        for (int i = 0; i < 16; i++) begin
            send((i * 97) % 700, (i * 37) % 620, (i * 3) % 4, i[1], "R8 stalled stream", w);
        end
        drain();
        bp_mode = 0;
        repeat (4) @(negedge clk);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule